// File: doc/BRIEF.md
# DMA Transfer-Request Register Queue

This block is the software-facing control front end of a single-channel DMA engine. A processor programs a staging set of registers (addresses, strides, X and Y counts, cyclic flag), then writes the start register. The block stamps the request with a rolling 5-bit transfer ID and places it in a small FIFO. The FIFO offers requests in order to a downstream data mover on a valid/ready port. The mover reports each finished transfer by pulsing a done strobe with the ID. The block records completions in a 32-bit per-ID bitmap. It keeps two interrupt events: one when the mover takes a request and a FIFO slot frees, one when a transfer ends. A mask and a write-one-to-clear scheme sit on top of these events.

Back-pressure rules on the request port: once `req_valid` is high it stays high, with the whole payload unchanged, until the cycle in which `req_ready` is high. That cycle is the handshake and pops the entry. The only exception is a disable write to the control register, which withdraws the offer at once. `req_ready` may be high or low in any cycle. The done port has no ready: each cycle with `done_valid` high counts as one completion. Software must leave the staging registers unchanged while the start register reads 1, because they are copied into the queue only when the submission is taken.

Register offsets (12-bit byte address): control 0x400 (bit 0 run, bit 1 hold), start 0x408, flags 0x40C (bit 0 cyclic), next-ID 0x404, destination and source address 0x410 and 0x414, X and Y count-minus-one 0x418 and 0x41C, destination and source stride 0x420 and 0x424, completion bitmap 0x428, last-taken ID 0x42C, status 0x430, mover source and destination position 0x434 and 0x438, interrupt mask 0x080, interrupt pending 0x084, raw events 0x088. Interrupt bit 0 is the slot-freed event and bit 1 is the transfer-ended event. Status holds: bit 0 submission waiting, bit 1 queue full, bit 2 queue empty, bit 3 run, bit 4 hold, bits 15:8 queue fill level.

Top module: `xrq_top`

## Requirements
- R1: After reset, `irq` and `req_valid` are 0, next-ID reads 0, the completion bitmap reads 0, the mask reads 0x3, and status bit 2 (empty) is 1.
- R2: Software writes 1 to the start register while run (control bit 0) is set and no submission is waiting. The staging registers are then copied into a queue entry carrying the current next-ID. The entry is offered on the request port from the second cycle after the write, with the cyclic flag taken from flags bit 0.
- R3: Next-ID (0x404) reads the ID the next queued request will receive. It advances by one each time a submission enters the queue, and it wraps from 31 to 0.
- R4: The request port obeys the valid/ready rules above, and entries leave in the order they were submitted.
- R5: The queue holds DEPTH entries (default 4). While it is full, a submission waits and the start register reads 1. The submission enters the queue, and start reads 0 again, in the cycle after a slot frees.
- R6: A request handshake sets raw event bit 0. A done strobe sets raw event bit 1. Raw events read at 0x088 regardless of the mask.
- R7: Pending (0x084) reads raw AND NOT mask, and `irq` is the OR of pending. Writing 1 to a pending bit clears that event, and writing 0 leaves it unchanged.
- R8: A done strobe with ID n sets bitmap bit n. The bit is cleared when ID n is assigned to a new submission.
- R9: While hold (control bit 1) is set, no new offer starts. An offer already in progress stays until its handshake, and clearing hold lets the queue drain.
- R10: A control write with bit 0 = 0 empties the queue, drops a waiting submission and drops `req_valid` in the next cycle. Start writes are ignored while run is 0, and next-ID does not change.
- R11: The last-taken ID register (0x42C) holds the ID of the most recent handshake. The X and Y registers keep only their low LEN_W bits. 0x434 and 0x438 read the mover position inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| req_valid | output | 1 | Request offered to mover |
| req_ready | input | 1 | Mover accepts request |
| req_id | output | 5 | Transfer ID of offered request |
| req_cyclic | output | 1 | Cyclic operation requested |
| req_dst_addr | output | 32 | Destination start address |
| req_src_addr | output | 32 | Source start address |
| req_x_len | output | 32 | X count minus one |
| req_y_len | output | 32 | Y count minus one |
| req_dst_stride | output | 32 | Destination line stride |
| req_src_stride | output | 32 | Source line stride |
| done_valid | input | 1 | A transfer has ended |
| done_id | input | 5 | ID of the ended transfer |
| mover_src_pos | input | 32 | Mover's current source address |
| mover_dst_pos | input | 32 | Mover's current destination address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the wrap of the ID counter onto an ID whose completion bit is still set. That state also needs the full queue with one submission still waiting. The stimulus holds `req_ready` low while five submissions are written, so the fifth waits behind a full queue. It then drains the queue and checks the order of the entries. Later it runs submission-and-accept pairs until the ID counter passes 31. It then checks that the stale completion bit for ID 0 is cleared when ID 0 is assigned again. Hold is exercised both before an offer exists and while one is in progress, and a disable is issued while a submission is waiting.

// File: rtl/xrq_pkg.sv
package xrq_pkg;
  localparam int ID_W = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int EVT_W = 2;

  localparam logic [11:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [11:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [11:0] OFS_IRQ_RAW  = 12'h088;
  localparam logic [11:0] OFS_CTRL     = 12'h400;
  localparam logic [11:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [11:0] OFS_START    = 12'h408;
  localparam logic [11:0] OFS_FLAGS    = 12'h40C;
  localparam logic [11:0] OFS_DST      = 12'h410;
  localparam logic [11:0] OFS_SRC      = 12'h414;
  localparam logic [11:0] OFS_XLEN     = 12'h418;
  localparam logic [11:0] OFS_YLEN     = 12'h41C;
  localparam logic [11:0] OFS_DSTR     = 12'h420;
  localparam logic [11:0] OFS_SSTR     = 12'h424;
  localparam logic [11:0] OFS_DONE     = 12'h428;
  localparam logic [11:0] OFS_LAST_ID  = 12'h42C;
  localparam logic [11:0] OFS_STATUS   = 12'h430;
  localparam logic [11:0] OFS_CUR_SRC  = 12'h434;
  localparam logic [11:0] OFS_CUR_DST  = 12'h438;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            cyclic;
    logic [31:0]     dst;
    logic [31:0]     src;
    logic [31:0]     xlen;
    logic [31:0]     ylen;
    logic [31:0]     dstr;
    logic [31:0]     sstr;
  } xrq_req_t;
endpackage

// File: rtl/xrq_fifo.sv
module xrq_fifo
  import xrq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  xrq_req_t         wr_data,
  input  logic             pop,
  output xrq_req_t         head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  xrq_req_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wr_data;
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/xrq_ids.sv
module xrq_ids
  import xrq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               assign_en,
  input  logic               issue_en,
  input  logic [ID_W-1:0]    issue_id,
  input  logic               done_valid,
  input  logic [ID_W-1:0]    done_id,
  output logic [ID_W-1:0]    next_id,
  output logic [NUM_IDS-1:0] done_map,
  output logic [ID_W-1:0]    last_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_id <= '0;
      last_id <= '0;
    end else begin
      if (assign_en) next_id <= next_id + 1'b1;
      if (issue_en)  last_id <= issue_id;
    end
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rst_n)
        done_map[g] <= 1'b0;
      else if (done_valid && done_id == ID_W'(g))
        done_map[g] <= 1'b1;
      else if (assign_en && next_id == ID_W'(g))
        done_map[g] <= 1'b0;
    end
  end

  a_r3_id_step: assert property (@(posedge clk) disable iff (!rst_n)
    assign_en |=> next_id == $past(next_id) + 1'b1);
  a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> done_map[$past(done_id)]);
  a_r8_reissue_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (assign_en && !(done_valid && done_id == next_id)) |=> !done_map[$past(next_id)]);
endmodule

// File: rtl/xrq_irq.sv
module xrq_irq
  import xrq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sot_evt,
  input  logic             eot_evt,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_wd,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_wd,
  output logic [EVT_W-1:0] mask,
  output logic [EVT_W-1:0] raw,
  output logic [EVT_W-1:0] pending,
  output logic             irq
);
  logic [EVT_W-1:0] clr_bits, new_bits;

  assign clr_bits = clr_we ? clr_wd : '0;
  assign new_bits = {eot_evt, sot_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      raw  <= '0;
    end else begin
      if (mask_we) mask <= mask_wd;
      raw <= (raw & ~clr_bits) | new_bits;
    end
  end

  assign pending = raw & ~mask;
  assign irq     = |pending;

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wd == '1 && !sot_evt && !eot_evt) |=> !irq);
  a_r6_sot_latch: assert property (@(posedge clk) disable iff (!rst_n)
    sot_evt |=> raw[0]);
  a_r6_eot_latch: assert property (@(posedge clk) disable iff (!rst_n)
    eot_evt |=> raw[1]);
endmodule

// File: rtl/xrq_top.sv
module xrq_top
  import xrq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ID_W-1:0]   req_id,
  output logic              req_cyclic,
  output logic [31:0]       req_dst_addr,
  output logic [31:0]       req_src_addr,
  output logic [31:0]       req_x_len,
  output logic [31:0]       req_y_len,
  output logic [31:0]       req_dst_stride,
  output logic [31:0]       req_src_stride,
  input  logic              done_valid,
  input  logic [ID_W-1:0]   done_id,
  input  logic [31:0]       mover_src_pos,
  input  logic [31:0]       mover_dst_pos,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [31:0] LEN_MASK = (LEN_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << LEN_W) - 32'd1);

  logic run_q, hold_q, cyc_q, wait_q, offer_q;
  logic [31:0] dst_q, src_q, xlen_q, ylen_q, dstr_q, sstr_q;

  logic wr_ctrl, wr_start, wr_flags, wr_dst, wr_src, wr_xlen, wr_ylen;
  logic wr_dstr, wr_sstr, wr_mask, wr_pend;
  assign wr_ctrl  = reg_we && reg_addr == ADDR_W'(OFS_CTRL);
  assign wr_start = reg_we && reg_addr == ADDR_W'(OFS_START);
  assign wr_flags = reg_we && reg_addr == ADDR_W'(OFS_FLAGS);
  assign wr_dst   = reg_we && reg_addr == ADDR_W'(OFS_DST);
  assign wr_src   = reg_we && reg_addr == ADDR_W'(OFS_SRC);
  assign wr_xlen  = reg_we && reg_addr == ADDR_W'(OFS_XLEN);
  assign wr_ylen  = reg_we && reg_addr == ADDR_W'(OFS_YLEN);
  assign wr_dstr  = reg_we && reg_addr == ADDR_W'(OFS_DSTR);
  assign wr_sstr  = reg_we && reg_addr == ADDR_W'(OFS_SSTR);
  assign wr_mask  = reg_we && reg_addr == ADDR_W'(OFS_IRQ_MASK);
  assign wr_pend  = reg_we && reg_addr == ADDR_W'(OFS_IRQ_PEND);

  logic flush, start_ok, push, pop;
  logic q_empty, q_full;
  logic [CNT_W-1:0] q_count;
  xrq_req_t stage, head;
  logic [ID_W-1:0] next_id, last_id;
  logic [NUM_IDS-1:0] done_map;
  logic [EVT_W-1:0] irq_mask, irq_raw, irq_pend;

  assign flush    = wr_ctrl && !reg_wdata[0];
  assign start_ok = wr_start && reg_wdata[0] && run_q && !wait_q;
  assign push     = wait_q && run_q && !q_full;
  assign req_valid = run_q && !q_empty && (!hold_q || offer_q);
  assign pop      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; hold_q <= 1'b0; cyc_q <= 1'b0;
      dst_q <= '0; src_q <= '0; xlen_q <= '0; ylen_q <= '0;
      dstr_q <= '0; sstr_q <= '0;
    end else begin
      if (wr_ctrl)  begin run_q <= reg_wdata[0]; hold_q <= reg_wdata[1]; end
      if (wr_flags) cyc_q  <= reg_wdata[0];
      if (wr_dst)   dst_q  <= reg_wdata;
      if (wr_src)   src_q  <= reg_wdata;
      if (wr_xlen)  xlen_q <= reg_wdata & LEN_MASK;
      if (wr_ylen)  ylen_q <= reg_wdata & LEN_MASK;
      if (wr_dstr)  dstr_q <= reg_wdata;
      if (wr_sstr)  sstr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wait_q  <= 1'b0;
      offer_q <= 1'b0;
    end else begin
      if (start_ok)  wait_q <= 1'b1;
      else if (push) wait_q <= 1'b0;
      offer_q <= req_valid && !req_ready;
    end
  end

  always_comb begin
    stage.id     = next_id;
    stage.cyclic = cyc_q;
    stage.dst    = dst_q;
    stage.src    = src_q;
    stage.xlen   = xlen_q;
    stage.ylen   = ylen_q;
    stage.dstr   = dstr_q;
    stage.sstr   = sstr_q;
  end

  xrq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wr_data(stage),
    .pop(pop), .head(head), .empty(q_empty), .full(q_full), .count(q_count)
  );

  xrq_ids u_ids (
    .clk(clk), .rst_n(rst_n), .assign_en(push), .issue_en(pop),
    .issue_id(head.id), .done_valid(done_valid), .done_id(done_id),
    .next_id(next_id), .done_map(done_map), .last_id(last_id)
  );

  xrq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sot_evt(pop), .eot_evt(done_valid),
    .mask_we(wr_mask), .mask_wd(reg_wdata[EVT_W-1:0]),
    .clr_we(wr_pend), .clr_wd(reg_wdata[EVT_W-1:0]),
    .mask(irq_mask), .raw(irq_raw), .pending(irq_pend), .irq(irq)
  );

  assign req_id         = head.id;
  assign req_cyclic     = head.cyclic;
  assign req_dst_addr   = head.dst;
  assign req_src_addr   = head.src;
  assign req_x_len      = head.xlen;
  assign req_y_len      = head.ylen;
  assign req_dst_stride = head.dstr;
  assign req_src_stride = head.sstr;

  logic [31:0] status;
  always_comb begin
    status        = '0;
    status[0]     = wait_q;
    status[1]     = q_full;
    status[2]     = q_empty;
    status[3]     = run_q;
    status[4]     = hold_q;
    status[15:8]  = 8'(q_count);
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_IRQ_MASK): reg_rdata = 32'(irq_mask);
      ADDR_W'(OFS_IRQ_PEND): reg_rdata = 32'(irq_pend);
      ADDR_W'(OFS_IRQ_RAW):  reg_rdata = 32'(irq_raw);
      ADDR_W'(OFS_CTRL):     reg_rdata = {30'b0, hold_q, run_q};
      ADDR_W'(OFS_NEXT_ID):  reg_rdata = 32'(next_id);
      ADDR_W'(OFS_START):    reg_rdata = {31'b0, wait_q};
      ADDR_W'(OFS_FLAGS):    reg_rdata = {31'b0, cyc_q};
      ADDR_W'(OFS_DST):      reg_rdata = dst_q;
      ADDR_W'(OFS_SRC):      reg_rdata = src_q;
      ADDR_W'(OFS_XLEN):     reg_rdata = xlen_q;
      ADDR_W'(OFS_YLEN):     reg_rdata = ylen_q;
      ADDR_W'(OFS_DSTR):     reg_rdata = dstr_q;
      ADDR_W'(OFS_SSTR):     reg_rdata = sstr_q;
      ADDR_W'(OFS_DONE):     reg_rdata = 32'(done_map);
      ADDR_W'(OFS_LAST_ID):  reg_rdata = 32'(last_id);
      ADDR_W'(OFS_STATUS):   reg_rdata = status;
      ADDR_W'(OFS_CUR_SRC):  reg_rdata = mover_src_pos;
      ADDR_W'(OFS_CUR_DST):  reg_rdata = mover_dst_pos;
      default:               reg_rdata = '0;
    endcase
  end

  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush) |=> req_valid && $stable(req_id) && $stable(req_x_len));
  a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !req_valid && !wr_ctrl) |=> !req_valid);
  a_r10_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !req_valid && !wait_q);
  a_r5_wait_until_room: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && q_full && !pop && !flush) |=> wait_q);
endmodule

// File: tb/xrq_top_tb_top.sv
`timescale 1ns/1ps
module xrq_top_tb_top;
  import xrq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic req_valid, req_ready = 1'b0;
  logic [4:0] req_id;
  logic req_cyclic;
  logic [31:0] req_dst_addr, req_src_addr, req_x_len, req_y_len, req_dst_stride, req_src_stride;
  logic done_valid = 1'b0;
  logic [4:0] done_id = '0;
  logic [31:0] mover_src_pos = '0, mover_dst_pos = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_id = '0;

  always #2.5 clk = ~clk;

  xrq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .req_cyclic(req_cyclic),
    .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
    .req_x_len(req_x_len), .req_y_len(req_y_len),
    .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
    .done_valid(done_valid), .done_id(done_id),
    .mover_src_pos(mover_src_pos), .mover_dst_pos(mover_dst_pos), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic submit();
    wr(OFS_START, 32'h1);
    @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_valid", 32'(req_valid), 0);
    rd(OFS_NEXT_ID, v); chk("R1 next id", v, 0);
    rd(OFS_DONE, v);    chk("R1 done map", v, 0);
    rd(OFS_IRQ_MASK, v); chk("R1 mask", v, 3);
    rd(OFS_STATUS, v);  chk("R1 status empty", 32'(v[2]), 1);
  endtask

  task automatic t_submit();
    logic [31:0] v;
    wr(OFS_DST, 32'h0000_1000); wr(OFS_SRC, 32'h0000_2000);
    wr(OFS_XLEN, 32'h3F); wr(OFS_YLEN, 32'h2);
    wr(OFS_DSTR, 32'h100); wr(OFS_SSTR, 32'h200); wr(OFS_FLAGS, 32'h1);
    chk("R2 no offer before start", 32'(req_valid), 0);
    submit();
    chk("R2 offer valid", 32'(req_valid), 1);
    chk("R2 offer id", 32'(req_id), 0);
    chk("R2 dst", req_dst_addr, 32'h1000);
    chk("R2 src", req_src_addr, 32'h2000);
    chk("R2 xlen", req_x_len, 32'h3F);
    chk("R2 ylen", req_y_len, 32'h2);
    chk("R2 strides", {req_dst_stride[15:0], req_src_stride[15:0]}, 32'h0100_0200);
    chk("R2 cyclic", 32'(req_cyclic), 1);
    rd(OFS_NEXT_ID, v); chk("R3 next id after submit", v, 1);
    repeat (3) @(negedge clk);
    chk("R4 offer held", 32'(req_valid), 1);
    chk("R4 id stable", 32'(req_id), 0);
    accept();
    chk("R4 popped", 32'(req_valid), 0);
    rd(OFS_IRQ_RAW, v);  chk("R6 slot event raw", v, 1);
    rd(OFS_IRQ_PEND, v); chk("R7 masked pending", v, 0);
    chk("R7 irq masked", 32'(irq), 0);
    rd(OFS_LAST_ID, v);  chk("R11 last id", v, 0);
    wr(OFS_IRQ_MASK, 32'h0);
    chk("R7 irq unmasked", 32'(irq), 1);
    wr(OFS_IRQ_PEND, 32'h2);
    chk("R7 zero bit keeps event", 32'(irq), 1);
    wr(OFS_IRQ_PEND, 32'h1);
    chk("R7 w1c irq", 32'(irq), 0);
    rd(OFS_IRQ_RAW, v); chk("R7 w1c raw", v, 0);
    exp_id = 5'd1;
  endtask

  task automatic t_done();
    logic [31:0] v;
    @(negedge clk); done_valid = 1'b1; done_id = 5'd0;
    @(negedge clk); done_valid = 1'b0;
    rd(OFS_DONE, v);    chk("R8 done bit0", v, 32'h1);
    rd(OFS_IRQ_RAW, v); chk("R6 end event raw", v, 32'h2);
    chk("R7 irq on end", 32'(irq), 1);
    wr(OFS_IRQ_PEND, 32'h3);
    chk("R7 cleared", 32'(irq), 0);
  endtask

  task automatic t_full_order();
    logic [31:0] v;
    int got;
    for (int i = 0; i < 4; i++) begin
      wr(OFS_XLEN, 32'(10 + i));
      submit();
    end
    rd(OFS_STATUS, v); chk("R5 full flag", 32'(v[1]), 1);
    wr(OFS_XLEN, 32'd14);
    submit();
    rd(OFS_START, v); chk("R5 start busy", v, 1);
    repeat (3) @(negedge clk);
    rd(OFS_START, v); chk("R5 still waiting", v, 1);
    rd(OFS_NEXT_ID, v); chk("R5 waiting has no id", v, 32'd5);
    got = 0;
    @(negedge clk); req_ready = 1'b1;
    for (int k = 0; k < 20; k++) begin
      if (got < 5 && req_valid) begin
        chk("R4 order id", 32'(req_id), 32'(exp_id));
        chk("R4 order xlen", req_x_len, 32'(10 + got));
        exp_id = exp_id + 1'b1;
        got++;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk("R5 all five delivered", 32'(got), 5);
    rd(OFS_START, v); chk("R5 start idle", v, 0);
  endtask

  task automatic t_hold();
    wr(OFS_CTRL, 32'h3);
    submit();
    repeat (3) @(negedge clk);
    chk("R9 no offer in hold", 32'(req_valid), 0);
    wr(OFS_CTRL, 32'h1);
    chk("R9 drains after hold", 32'(req_valid), 1);
    chk("R9 id", 32'(req_id), 32'(exp_id));
    accept(); exp_id = exp_id + 1'b1;
    submit();
    chk("R9 offer live", 32'(req_valid), 1);
    wr(OFS_CTRL, 32'h3);
    @(negedge clk);
    chk("R9 live offer kept", 32'(req_valid), 1);
    chk("R9 live id kept", 32'(req_id), 32'(exp_id));
    accept(); exp_id = exp_id + 1'b1;
    chk("R9 taken", 32'(req_valid), 0);
    wr(OFS_CTRL, 32'h1);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) submit();
    exp_id = exp_id + 5'd4;
    rd(OFS_START, v); chk("R10 pre waiting", v, 1);
    wr(OFS_CTRL, 32'h0);
    chk("R10 offer dropped", 32'(req_valid), 0);
    rd(OFS_START, v);  chk("R10 waiting dropped", v, 0);
    rd(OFS_STATUS, v); chk("R10 empty", 32'(v[2]), 1);
    wr(OFS_START, 32'h1);
    rd(OFS_START, v);  chk("R10 start ignored", v, 0);
    rd(OFS_NEXT_ID, v); chk("R10 id unchanged", v, 32'(exp_id));
    wr(OFS_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 nothing left", 32'(req_valid), 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    while (exp_id != 5'd0) begin
      submit();
      chk("R3 sequential id", 32'(req_id), 32'(exp_id));
      accept();
      exp_id = exp_id + 1'b1;
    end
    rd(OFS_NEXT_ID, v); chk("R3 wrapped to 0", v, 0);
    rd(OFS_DONE, v);    chk("R8 stale bit0 set", 32'(v[0]), 1);
    submit();
    chk("R3 reissued id 0", 32'(req_id), 0);
    rd(OFS_DONE, v);    chk("R8 bit0 cleared on reissue", 32'(v[0]), 0);
    accept();
    rd(OFS_LAST_ID, v); chk("R11 last id after wrap", v, 0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    mover_src_pos = 32'hCAFE_0010; mover_dst_pos = 32'hBEEF_0020;
    rd(OFS_CUR_SRC, v); chk("R11 mover src", v, 32'hCAFE_0010);
    rd(OFS_CUR_DST, v); chk("R11 mover dst", v, 32'hBEEF_0020);
    wr(OFS_XLEN, 32'hFFFF_FFFF);
    rd(OFS_XLEN, v); chk("R11 xlen width", v, 32'h00FF_FFFF);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(OFS_CTRL, 32'h1);
    t_submit();
    t_done();
    t_full_order();
    t_hold();
    t_flush();
    t_wrap();
    t_misc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule